// File: doc/BRIEF.md
# Black Level Servo Loop

This block holds the dark level of a sensor signal chain at a programmed code. Every sample clock it takes the converter's output word and, while a dark-reference window is open, compares it with a black target code. A sample below the target steps a signed correction word up by one, a sample above steps it down by one, and an equal sample leaves it alone. The correction goes back ahead of the converter as an offset. While the window is closed the correction is held, so the value learned on the dark pixels carries over the active picture.

The window comes from the optical-black strobe in sensor mode, or from the alternate clamp strobe when the direct input feeds the gain stage. When the direct input goes straight to the converter, the loop stays idle. One polarity control inverts whichever strobe is in use. The correction returns to zero when the reset register bit is set, when standby is requested by pin or register, or while the reset pin is low. A settled flag reports that the recent in-window samples have stayed close to the target.

Top module: `blc_servo`

## Requirements
- R1: While rst_ni is low, corr_o is 0 and settled_o is 0, and both take effect without waiting for a clock edge.
- R2: In sensor mode (in_mode_i = 2'b00) with win_inv_i = 0, each clock on which ob_win_i is 0 changes corr_o at that edge by +1 when adc_code_i is below the effective target, by -1 when it is above, and by 0 when it is equal.
- R3: With win_inv_i = 1 the window is open while the selected strobe is 1 and closed while it is 0.
- R4: On a clock where the window is closed, corr_o keeps its value whatever adc_code_i is.
- R5: On any clock where blk_rst_i = 1, stby_ni = 0 or stby_reg_i = 1, corr_o becomes 0 and the settle count restarts. This takes priority over stepping.
- R6: In direct-to-gain mode (in_mode_i = 2'b01) alt_clamp_i gates the loop in place of ob_win_i, and ob_win_i has no effect.
- R7: In direct-to-converter mode (in_mode_i = 2'b10 or 2'b11) corr_o is never stepped.
- R8: corr_o is a 12-bit two's complement value that saturates at +2047 and at -2048 and never wraps.
- R9: The target comes from target_i (1 to 127). A target_i of 0 is not allowed and is replaced by 64.
- R10: settled_o goes to 1 after 8 consecutive in-window samples whose codes lie within ±1 of the target. One in-window sample outside that band clears the count and the flag. Closed-window samples neither add to the count nor clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the correction |
| adc_code_i | input | 10 | Converter output word for this sample |
| target_i | input | 7 | Black target code; 0 selects 64 |
| in_mode_i | input | 2 | 00 sensor, 01 direct to gain, 1x direct to converter |
| ob_win_i | input | 1 | Optical-black window strobe |
| alt_clamp_i | input | 1 | Clamp strobe used as the window in direct-to-gain mode |
| win_inv_i | input | 1 | Inverts the polarity of the window strobe in use |
| blk_rst_i | input | 1 | Register bit that clears the correction |
| stby_ni | input | 1 | Standby pin, active low |
| stby_reg_i | input | 1 | Standby register bit |
| corr_o | output | 12 | Signed offset correction |
| settled_o | output | 1 | Loop has stayed near target for the required run |

## Verification
The assertions assume that every input is a known value at each rising clock and that the reset pin alone acts asynchronously. Mode, polarity, target and clear inputs are treated as sampled levels, with nothing assumed about how long they stay stable. The bench changes every input only on the falling clock edge. It keeps all of them at 0 or 1 from time zero, and it lowers rst_ni between edges to show that the clear does not wait for a clock. Targets, codes and modes then change freely between cycles, including target 0 and runs long enough to reach both saturation limits.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    MODE_SENSOR   = 2'b00,
    MODE_DIR_GAIN = 2'b01,
    MODE_DIR_ADC0 = 2'b10,
    MODE_DIR_ADC1 = 2'b11
  } in_mode_e;
endpackage

// File: rtl/blc_gate.sv
module blc_gate
  import blc_pkg::*;
(
  input  logic       ob_win_i,
  input  logic       alt_clamp_i,
  input  logic       win_inv_i,
  input  logic [1:0] in_mode_i,
  output logic       active_o
);
  in_mode_e mode;
  assign mode = in_mode_e'(in_mode_i);

  // strobes are active low unless inverted
  always_comb begin
    unique case (mode)
      MODE_SENSOR:   active_o = (ob_win_i ^ win_inv_i) == 1'b0;
      MODE_DIR_GAIN: active_o = (alt_clamp_i ^ win_inv_i) == 1'b0;
      default:       active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/blc_cmp.sv
module blc_cmp #(
  parameter int CODE_W      = 10,
  parameter int TGT_W       = 7,
  parameter int TGT_DEFAULT = 64
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic              active_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              hit_o,
  output logic              miss_o
);
  localparam int EW = CODE_W + 1;

  logic [TGT_W-1:0] tgt_eff;
  logic [EW-1:0]    code_x, tgt_x;
  logic             below, above, near;

  assign tgt_eff = (target_i == '0) ? TGT_W'(TGT_DEFAULT) : target_i;
  assign code_x  = EW'(code_i);
  assign tgt_x   = EW'(tgt_eff);
  assign below   = code_x < tgt_x;
  assign above   = code_x > tgt_x;
  assign near    = (code_x + EW'(1) >= tgt_x) && (code_x <= tgt_x + EW'(1));

  assign up_o   = active_i & below;
  assign dn_o   = active_i & above;
  assign hit_o  = active_i & near;
  assign miss_o = active_i & ~near;
endmodule

// File: rtl/blc_acc.sv
module blc_acc #(
  parameter int CORR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CORR_W-1:0] corr_o
);
  localparam logic [CORR_W-1:0] MAX_V = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic [CORR_W-1:0] MIN_V = {1'b1, {(CORR_W-1){1'b0}}};

  logic [CORR_W-1:0] corr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       corr_q <= '0;
    else if (clr_i)                    corr_q <= '0;
    else if (up_i && corr_q != MAX_V)  corr_q <= corr_q + CORR_W'(1);
    else if (dn_i && corr_q != MIN_V)  corr_q <= corr_q - CORR_W'(1);
  end

  assign corr_o = corr_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> corr_q == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !up_i && !dn_i) |=> $stable(corr_q));
  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_i && corr_q != MAX_V) |=> corr_q == $past(corr_q) + CORR_W'(1));
  // R8
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_i && corr_q == MAX_V) |=> corr_q == MAX_V);
  // R8
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dn_i && corr_q == MIN_V) |=> corr_q == MIN_V);
endmodule

// File: rtl/blc_settle.sv
module blc_settle #(
  parameter int SETTLE_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic settled_o
);
  localparam int CNT_W = $clog2(SETTLE_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(SETTLE_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || miss_i)        cnt_q <= '0;
    else if (hit_i && cnt_q != LEN_V) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign settled_o = (cnt_q == LEN_V);

  // R10
  settle_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> !settled_o);
  // R10
  settle_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> $past(hit_i && !clr_i));
endmodule

// File: rtl/blc_servo.sv
module blc_servo #(
  parameter int CODE_W      = 10,
  parameter int TGT_W       = 7,
  parameter int TGT_DEFAULT = 64,
  parameter int CORR_W      = 12,
  parameter int SETTLE_LEN  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] adc_code_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [1:0]        in_mode_i,
  input  logic              ob_win_i,
  input  logic              alt_clamp_i,
  input  logic              win_inv_i,
  input  logic              blk_rst_i,
  input  logic              stby_ni,
  input  logic              stby_reg_i,
  output logic [CORR_W-1:0] corr_o,
  output logic              settled_o
);
  logic active, up, dn, hit, miss, clr;

  // any clear cause wins over stepping
  assign clr = blk_rst_i | ~stby_ni | stby_reg_i;

  blc_gate u_gate (
    .ob_win_i    (ob_win_i),
    .alt_clamp_i (alt_clamp_i),
    .win_inv_i   (win_inv_i),
    .in_mode_i   (in_mode_i),
    .active_o    (active)
  );

  blc_cmp #(
    .CODE_W      (CODE_W),
    .TGT_W       (TGT_W),
    .TGT_DEFAULT (TGT_DEFAULT)
  ) u_cmp (
    .code_i   (adc_code_i),
    .target_i (target_i),
    .active_i (active),
    .up_o     (up),
    .dn_o     (dn),
    .hit_o    (hit),
    .miss_o   (miss)
  );

  blc_acc #(.CORR_W(CORR_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .up_i   (up),
    .dn_i   (dn),
    .corr_o (corr_o)
  );

  blc_settle #(.SETTLE_LEN(SETTLE_LEN)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .hit_i     (hit),
    .miss_i    (miss),
    .settled_o (settled_o)
  );

  // R2
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up && dn));
  // R7
  adc_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i[1] && !clr) |=> $stable(corr_o));
  // R6
  gain_mode_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i == 2'b01 && (alt_clamp_i ^ win_inv_i) && !clr) |=> $stable(corr_o));
  // R5
  stby_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_ni |=> (corr_o == '0 && !settled_o));
endmodule

// File: tb/blc_servo_tb.sv
module blc_servo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  adc_code_i = '0;
  logic [6:0]  target_i = 7'd64;
  logic [1:0]  in_mode_i = 2'b00;
  logic        ob_win_i = 1'b1;
  logic        alt_clamp_i = 1'b1;
  logic        win_inv_i = 1'b0;
  logic        blk_rst_i = 1'b0;
  logic        stby_ni = 1'b1;
  logic        stby_reg_i = 1'b0;
  logic [11:0] corr_o;
  logic        settled_o;

  int vectors = 0, fails = 0;
  int m_corr = 0, m_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  blc_servo dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adc_code_i(adc_code_i), .target_i(target_i),
    .in_mode_i(in_mode_i), .ob_win_i(ob_win_i), .alt_clamp_i(alt_clamp_i),
    .win_inv_i(win_inv_i), .blk_rst_i(blk_rst_i), .stby_ni(stby_ni),
    .stby_reg_i(stby_reg_i), .corr_o(corr_o), .settled_o(settled_o)
  );

  function automatic void model_edge();
    int tgt;
    bit open;
    if (!rst_ni) begin m_corr = 0; m_cnt = 0; return; end
    tgt = (target_i == 0) ? 64 : int'(target_i);
    if (in_mode_i == 2'b00)      open = (ob_win_i == win_inv_i);
    else if (in_mode_i == 2'b01) open = (alt_clamp_i == win_inv_i);
    else                         open = 0;
    if (blk_rst_i || !stby_ni || stby_reg_i) begin m_corr = 0; m_cnt = 0; return; end
    if (open) begin
      if (int'(adc_code_i) < tgt && m_corr < 2047) m_corr++;
      else if (int'(adc_code_i) > tgt && m_corr > -2048) m_corr--;
      if (int'(adc_code_i) >= tgt - 1 && int'(adc_code_i) <= tgt + 1)
        m_cnt = (m_cnt < 8) ? m_cnt + 1 : 8;
      else m_cnt = 0;
    end
  endfunction

  task automatic compare(string tag);
    int got;
    got = int'($signed(corr_o));
    vectors++;
    if (got != m_corr || settled_o !== (m_cnt >= 8)) begin
      fails++;
      $display("FAIL %s: corr=%0d settled=%b expected corr=%0d settled=%b",
               tag, got, settled_o, m_corr, (m_cnt >= 8));
    end
  endtask

  task automatic tick(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      compare(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD/4);
    compare("R1 reset");
    tick("R1 reset held", 3);
    rst_ni = 1'b1;

    // R9 target 0 acts as 64
    target_i = 7'd0; ob_win_i = 1'b0;
    adc_code_i = 10'd63; tick("R9 below 64", 5);
    adc_code_i = 10'd65; tick("R9 above 64", 2);
    adc_code_i = 10'd64; tick("R9 equal 64", 2);

    // R2 stepping against a programmed target
    target_i = 7'd40;
    adc_code_i = 10'd10;  tick("R2 below", 6);
    adc_code_i = 10'd900; tick("R2 above", 9);
    adc_code_i = 10'd40;  tick("R2 equal", 3);

    // R4 closed window holds
    ob_win_i = 1'b1;
    adc_code_i = 10'd0;    tick("R4 hold low code", 4);
    adc_code_i = 10'd1023; tick("R4 hold high code", 4);

    // R3 inverted polarity
    win_inv_i = 1'b1; ob_win_i = 1'b1; adc_code_i = 10'd5; tick("R3 open high", 5);
    ob_win_i = 1'b0; tick("R3 closed low", 4);
    win_inv_i = 1'b0;

    // R10 settle run
    ob_win_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      adc_code_i = 10'(39 + (i % 3));
      tick("R10 near run");
    end
    ob_win_i = 1'b1; adc_code_i = 10'd900; tick("R10 closed keeps flag", 3);
    ob_win_i = 1'b0; adc_code_i = 10'd45; tick("R10 miss clears");
    adc_code_i = 10'd41; tick("R10 partial run", 7);
    ob_win_i = 1'b1; adc_code_i = 10'd0; tick("R10 closed no count", 2);
    ob_win_i = 1'b0; adc_code_i = 10'd39; tick("R10 eighth sample");

    // R6 direct-to-gain gating by alt clamp
    in_mode_i = 2'b01;
    alt_clamp_i = 1'b1; ob_win_i = 1'b0; adc_code_i = 10'd0; tick("R6 alt closed ob ignored", 4);
    alt_clamp_i = 1'b0; ob_win_i = 1'b1; tick("R6 alt open", 5);
    win_inv_i = 1'b1; alt_clamp_i = 1'b1; adc_code_i = 10'd600; tick("R6 alt inverted", 3);
    win_inv_i = 1'b0;

    // R7 direct-to-converter: no stepping
    in_mode_i = 2'b10; alt_clamp_i = 1'b0; ob_win_i = 1'b0; adc_code_i = 10'd0;
    tick("R7 mode 10", 5);
    in_mode_i = 2'b11; adc_code_i = 10'd1000; tick("R7 mode 11", 5);
    in_mode_i = 2'b00;

    // R5 each clear cause
    adc_code_i = 10'd0;
    blk_rst_i = 1'b1; tick("R5 reg bit clear", 2); blk_rst_i = 1'b0;
    tick("R5 regrow", 4);
    stby_ni = 1'b0; tick("R5 standby pin", 2); stby_ni = 1'b1;
    tick("R5 regrow", 3);
    stby_reg_i = 1'b1; tick("R5 standby reg", 2); stby_reg_i = 1'b0;
    tick("R5 regrow", 2);

    // R8 saturation
    target_i = 7'd127; adc_code_i = 10'd0;    tick("R8 toward max", 2100);
    adc_code_i = 10'd1023;                    tick("R8 toward min", 4200);
    adc_code_i = 10'd0;                       tick("R8 leave min", 3);

    // R1 asynchronous reset mid-cycle
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    m_corr = 0; m_cnt = 0;
    compare("R1 async reset");
    @(negedge clk_i);
    tick("R1 reset held", 2);
    rst_ni = 1'b1;
    tick("R1 after release", 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule